// File: doc/BRIEF.md
# Fractional-N clock divider

This block turns a fast source clock into a transmit bit-clock for an audio serial port. The division ratio is an integer N plus a fraction b/a. It gets that ratio by mixing periods that are N source cycles long with periods that are N+1 cycles long. Within every run of a periods, exactly b are long. The long periods are not spread one by one. They come in even groups, so the pattern is regular and needs only small counters.

The block gives out two signals. The first is a tick that lasts one source cycle at the start of every divided period. The second is a divided clock that is high for roughly the first half of every period. Two enables must both be set for anything to come out: a clock-gate enable and a transmit-active enable. The block also registers a 2-bit source-select code and passes it on to the clock-source multiplexer, which lives outside this block.

Top module: `frac_clk_div`

## Requirements
- R1: Over one full pattern of a periods, the time from the first tick to the tick a periods later is a*N+b source cycles. So the average divided frequency is the source frequency divided by N+b/a.
- R2: Within each pattern, exactly b periods last N+1 cycles and exactly a-b periods last N cycles.
- R3: When 0 < b < a and 2b <= a, the pattern has three parts. With x = (a-b) div b and y = (a-b) mod b, it is b groups, each of x periods of N followed by one period of N+1. Then y more periods of N follow.
- R4: When 0 < b < a and 2b > a, the pattern has three parts. With x = b div (a-b) and y = b mod (a-b), it is a-b groups, each of one period of N followed by x periods of N+1. Then y more periods of N+1 follow.
- R5: When b = 0, a = 0 or b >= a, every period lasts exactly N cycles. A value of N below 2 is treated as 2.
- R6: N, a and b are taken in on two occasions only: on the clock edge that starts the divider, and on the edge that ends the last period of a pattern. A change made in the middle of a pattern first shows in the next pattern.
- R7: The tick is high on the first source cycle of each period and low on the others. The divided clock is high for the first floor(L/2) cycles of a period of length L and low for the rest.
- R8: While the gate enable or the active enable is low, the tick and the divided clock stay low. The edge that first sees both enables high starts a new pattern, and the tick is high in the cycle that follows that edge.
- R9: `src_sel_o` equals `src_sel_i` delayed by SEL_STAGES clock edges, whatever the enables are. The codes are: 0 crystal oscillator, 1 audio PLL, 2 fixed 160 MHz clock, 3 external master clock.
- R10: While reset is asserted, the tick, the divided clock and `src_sel_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_en_i | input | 1 | Clock-gate enable |
| active_en_i | input | 1 | Transmit-active enable |
| div_int_i | input | NW | Integer part N of the ratio |
| frac_den_i | input | AW | Fraction denominator a |
| frac_num_i | input | AW | Fraction numerator b |
| src_sel_i | input | 2 | Source-select code |
| tick_o | output | 1 | One-cycle pulse at the start of each period |
| div_clk_o | output | 1 | Divided clock, close to 50 % duty |
| src_sel_o | output | 2 | Registered source-select code |

## Verification
The bench builds the block with NW=6, AW=4 and SEL_STAGES=2. A 4-bit denominator keeps every pattern under 16 periods, so several whole patterns fit in each test phase, including a change of settings in the middle of a pattern. The 6-bit integer field still accepts 0 and 1, which brings the minimum-divide clamp within reach. Two select stages build the chained branch of the select pipeline rather than the single-register branch.

// File: rtl/frac_clk_div_pkg.sv
package frac_clk_div_pkg;

   // source-select encoding (R9)
   typedef enum logic [1:0] {
      SRC_CRYSTAL    = 2'd0,
      SRC_AUDIO_PLL  = 2'd1,
      SRC_FIXED_160M = 2'd2,
      SRC_EXT_MASTER = 2'd3
   } clk_src_e;

   // smallest integer divide that still yields a high and a low phase
   localparam int unsigned MIN_DIV = 2;

endpackage

// File: rtl/frac_div_plan.sv
// Works out the grouping of short and long periods from the raw ratio (R3, R4, R5).
module frac_div_plan #(
   parameter int NW = 8,
   parameter int AW = 6
) (
   input  logic [NW-1:0] div_int_i,
   input  logic [AW-1:0] den_i,
   input  logic [AW-1:0] num_i,
   output logic [NW-1:0] n_eff_o,
   output logic          frac_on_o,
   output logic          major_long_o,
   output logic [AW-1:0] grp_cnt_o,
   output logic [AW-1:0] run_len_o,
   output logic [AW-1:0] tail_len_o
);
   import frac_clk_div_pkg::*;

   localparam logic [NW-1:0] N_FLOOR = NW'(MIN_DIV);

   logic [AW-1:0] minor_cnt;
   logic [AW-1:0] major_cnt;
   logic [AW-1:0] divisor;
   logic [AW:0]   num_x2;

   always_comb begin
      n_eff_o      = (div_int_i < N_FLOOR) ? N_FLOOR : div_int_i;
      frac_on_o    = (den_i != '0) && (num_i != '0) && (num_i < den_i);
      num_x2       = {num_i, 1'b0};
      major_long_o = frac_on_o && (num_x2 > {1'b0, den_i});
      if (major_long_o) begin
         minor_cnt = den_i - num_i;
         major_cnt = num_i;
      end else begin
         minor_cnt = num_i;
         major_cnt = den_i - num_i;
      end
      divisor    = frac_on_o ? minor_cnt : AW'(1);
      grp_cnt_o  = frac_on_o ? minor_cnt : '0;
      run_len_o  = frac_on_o ? (major_cnt / divisor) : '0;
      tail_len_o = frac_on_o ? (major_cnt % divisor) : '0;
   end

endmodule

// File: rtl/frac_div_seq.sv
// Walks through the periods of one pattern and picks each period's length (R2, R3, R4, R6).
module frac_div_seq #(
   parameter int NW = 8,
   parameter int AW = 6
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          en_i,
   input  logic          period_end_i,
   input  logic [NW-1:0] n_eff_i,
   input  logic          frac_on_i,
   input  logic          major_long_i,
   input  logic [AW-1:0] grp_cnt_i,
   input  logic [AW-1:0] run_len_i,
   input  logic [AW-1:0] tail_len_i,
   output logic          run_o,
   output logic [NW:0]   period_len_o
);
   logic          run_q;
   logic [NW-1:0] n_q;
   logic          frac_q;
   logic          mlong_q;
   logic [AW-1:0] x_q;
   logic [AW-1:0] y_q;
   logic [AW-1:0] grp_left_q;
   logic [AW-1:0] pos_q;
   logic          in_tail_q;
   logic [AW-1:0] tail_left_q;

   logic cur_long;
   logic grp_done;
   logic last_period;
   logic load;
   logic step;

   always_comb begin
      grp_done = (pos_q == x_q);
      if (!frac_q) begin
         cur_long = 1'b0;
      end else if (in_tail_q) begin
         cur_long = mlong_q;
      end else if (mlong_q) begin
         cur_long = (pos_q != '0);
      end else begin
         cur_long = grp_done;
      end
      if (!frac_q) begin
         last_period = 1'b1;
      end else if (in_tail_q) begin
         last_period = (tail_left_q == AW'(1));
      end else begin
         last_period = grp_done && (grp_left_q == AW'(1)) && (y_q == '0);
      end
      load = en_i && (!run_q || (period_end_i && last_period));
      step = en_i && run_q && period_end_i && !last_period;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q       <= 1'b0;
         n_q         <= '0;
         frac_q      <= 1'b0;
         mlong_q     <= 1'b0;
         x_q         <= '0;
         y_q         <= '0;
         grp_left_q  <= '0;
         pos_q       <= '0;
         in_tail_q   <= 1'b0;
         tail_left_q <= '0;
      end else if (!en_i) begin
         run_q       <= 1'b0;
         n_q         <= '0;
         frac_q      <= 1'b0;
         mlong_q     <= 1'b0;
         x_q         <= '0;
         y_q         <= '0;
         grp_left_q  <= '0;
         pos_q       <= '0;
         in_tail_q   <= 1'b0;
         tail_left_q <= '0;
      end else if (load) begin
         run_q       <= 1'b1;
         n_q         <= n_eff_i;
         frac_q      <= frac_on_i;
         mlong_q     <= major_long_i;
         x_q         <= run_len_i;
         y_q         <= tail_len_i;
         grp_left_q  <= grp_cnt_i;
         pos_q       <= '0;
         in_tail_q   <= 1'b0;
         tail_left_q <= tail_len_i;
      end else if (step) begin
         if (in_tail_q) begin
            tail_left_q <= tail_left_q - AW'(1);
         end else if (grp_done) begin
            pos_q      <= '0;
            grp_left_q <= grp_left_q - AW'(1);
            if (grp_left_q == AW'(1)) begin
               in_tail_q <= 1'b1;
            end
         end else begin
            pos_q <= pos_q + AW'(1);
         end
      end
   end

   assign run_o        = run_q;
   assign period_len_o = {1'b0, n_q} + (NW+1)'(cur_long);

endmodule

// File: rtl/frac_div_period.sv
// Counts source cycles within one period and shapes the tick and the divided clock (R7).
module frac_div_period #(
   parameter int NW = 8
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        run_i,
   input  logic [NW:0] len_i,
   output logic        tick_o,
   output logic        div_clk_o,
   output logic        end_o
);
   logic [NW:0] cnt_q;
   logic        at_last;

   assign at_last   = (cnt_q == (len_i - (NW+1)'(1)));
   assign end_o     = run_i && at_last;
   assign tick_o    = run_i && (cnt_q == '0);
   assign div_clk_o = run_i && (cnt_q < (len_i >> 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!run_i || at_last) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + (NW+1)'(1);
      end
   end

endmodule

// File: rtl/frac_div_sel_pipe.sv
// Register chain that carries the source-select code out (R9, R10).
module frac_div_sel_pipe #(
   parameter int STAGES = 1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] sel_i,
   output logic [1:0] sel_o
);
   import frac_clk_div_pkg::*;

   clk_src_e sel_in;
   assign sel_in = clk_src_e'(sel_i);

   if (STAGES == 1) begin : g_single
      clk_src_e sel_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            sel_q <= SRC_CRYSTAL;
         end else begin
            sel_q <= sel_in;
         end
      end
      assign sel_o = sel_q;
   end else begin : g_chain
      logic [2*STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            chain_q <= '0;
         end else begin
            chain_q <= {chain_q[2*STAGES-3:0], sel_in};
         end
      end
      assign sel_o = chain_q[2*STAGES-1 -: 2];
   end

endmodule

// File: rtl/frac_clk_div.sv
// Fractional-N divider top: ratio planner, period sequencer, cycle counter, select pipe.
module frac_clk_div #(
   parameter int NW         = 8,
   parameter int AW         = 6,
   parameter int SEL_STAGES = 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          gate_en_i,
   input  logic          active_en_i,
   input  logic [NW-1:0] div_int_i,
   input  logic [AW-1:0] frac_den_i,
   input  logic [AW-1:0] frac_num_i,
   input  logic [1:0]    src_sel_i,
   output logic          tick_o,
   output logic          div_clk_o,
   output logic [1:0]    src_sel_o
);
   if (NW < 2) begin : g_bad_nw
      $error("frac_clk_div: NW must be at least 2");
   end
   if (AW < 2) begin : g_bad_aw
      $error("frac_clk_div: AW must be at least 2");
   end
   if (SEL_STAGES < 1) begin : g_bad_stages
      $error("frac_clk_div: SEL_STAGES must be at least 1");
   end

   logic          en;
   logic          run;
   logic          period_end;
   logic [NW:0]   period_len;
   logic [NW-1:0] n_eff;
   logic          frac_on;
   logic          major_long;
   logic [AW-1:0] grp_cnt;
   logic [AW-1:0] run_len;
   logic [AW-1:0] tail_len;

   // both enables required (R8)
   assign en = gate_en_i && active_en_i;

   frac_div_plan #(.NW(NW), .AW(AW)) u_plan (
      .div_int_i    (div_int_i),
      .den_i        (frac_den_i),
      .num_i        (frac_num_i),
      .n_eff_o      (n_eff),
      .frac_on_o    (frac_on),
      .major_long_o (major_long),
      .grp_cnt_o    (grp_cnt),
      .run_len_o    (run_len),
      .tail_len_o   (tail_len)
   );

   frac_div_seq #(.NW(NW), .AW(AW)) u_seq (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (en),
      .period_end_i (period_end),
      .n_eff_i      (n_eff),
      .frac_on_i    (frac_on),
      .major_long_i (major_long),
      .grp_cnt_i    (grp_cnt),
      .run_len_i    (run_len),
      .tail_len_i   (tail_len),
      .run_o        (run),
      .period_len_o (period_len)
   );

   frac_div_period #(.NW(NW)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run),
      .len_i     (period_len),
      .tick_o    (tick_o),
      .div_clk_o (div_clk_o),
      .end_o     (period_end)
   );

   frac_div_sel_pipe #(.STAGES(SEL_STAGES)) u_sel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (src_sel_i),
      .sel_o  (src_sel_o)
   );

endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
   parameter int NW = 8
) (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        gate_en_i,
   input logic        active_en_i,
   input logic        tick_i,
   input logic        div_clk_i,
   input logic        run_i,
   input logic        period_end_i,
   input logic [NW:0] period_len_i
);
   localparam logic [NW+1:0] GAP_MAX = {2'b01, {NW{1'b0}}};

   logic          en_prev_q;
   logic [NW+1:0] gap_q;
   logic          gap_valid_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_prev_q   <= 1'b0;
         gap_q       <= '0;
         gap_valid_q <= 1'b0;
      end else begin
         en_prev_q <= gate_en_i && active_en_i;
         if (tick_i) begin
            gap_q       <= (NW+2)'(1);
            gap_valid_q <= 1'b1;
         end else if (!run_i) begin
            gap_q       <= '0;
            gap_valid_q <= 1'b0;
         end else if (gap_q != '1) begin
            gap_q <= gap_q + (NW+2)'(1);
         end
      end
   end

   // R8: either enable low silences both outputs on the next cycle
   p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(gate_en_i && active_en_i) |=> (!tick_i && !div_clk_i));

   // R8: first edge with both enables high gives a tick next cycle
   p_start_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_en_i && active_en_i && !en_prev_q) |=> tick_i);

   // R7: divided clock is high in the tick cycle
   p_tick_clk_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i |-> div_clk_i);

   // R7: counter wrap is followed by a tick while still enabled
   p_end_next_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (period_end_i && gate_en_i && active_en_i) |=> tick_i);

   // R1: tick-to-tick spacing stays within the legal period range
   p_gap_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && gap_valid_q) |-> ((gap_q >= (NW+2)'(2)) && (gap_q <= GAP_MAX)));

   // R5: a running period is never shorter than the minimum divide
   p_len_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i |-> (period_len_i >= (NW+1)'(2)));

endmodule

bind frac_clk_div frac_clk_div_chk #(.NW(NW)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .gate_en_i    (gate_en_i),
   .active_en_i  (active_en_i),
   .tick_i       (tick_o),
   .div_clk_i    (div_clk_o),
   .run_i        (run),
   .period_end_i (period_end),
   .period_len_i (period_len)
);

// File: tb/frac_clk_div_tb_top.sv
module frac_clk_div_tb_top;
   localparam int NW = 6;
   localparam int AW = 4;
   localparam int SS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          gate = 1'b0;
   logic          act = 1'b0;
   logic [NW-1:0] nval = '0;
   logic [AW-1:0] aval = '0;
   logic [AW-1:0] bval = '0;
   logic [1:0]    sel = '0;
   logic          tick;
   logic          dclk;
   logic [1:0]    selo;

   always #5 clk = ~clk;

   frac_clk_div #(.NW(NW), .AW(AW), .SEL_STAGES(SS)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .gate_en_i   (gate),
      .active_en_i (act),
      .div_int_i   (nval),
      .frac_den_i  (aval),
      .frac_num_i  (bval),
      .src_sel_i   (sel),
      .tick_o      (tick),
      .div_clk_o   (dclk),
      .src_sel_o   (selo)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R10";
   bit    done = 0;

   task automatic chk(input string req, input string what, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, actual, expected, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit   m_run = 0;
   int   m_cnt = 0;
   int   m_len = 2;
   int   pat[$];
   int   m_sel[SS];

   function automatic void build_pat();
      int n, a, b, z, x, y;
      n = (int'(nval) < 2) ? 2 : int'(nval);
      a = int'(aval);
      b = int'(bval);
      if (a == 0 || b == 0 || b >= a) begin
         pat.push_back(n);
      end else if (2 * b <= a) begin
         z = b; x = (a - b) / b; y = (a - b) % b;
         for (int g = 0; g < z; g++) begin
            for (int k = 0; k < x; k++) pat.push_back(n);
            pat.push_back(n + 1);
         end
         for (int k = 0; k < y; k++) pat.push_back(n);
      end else begin
         z = a - b; x = b / (a - b); y = b % (a - b);
         for (int g = 0; g < z; g++) begin
            pat.push_back(n);
            for (int k = 0; k < x; k++) pat.push_back(n + 1);
         end
         for (int k = 0; k < y; k++) pat.push_back(n + 1);
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_cnt = 0; m_len = 2; pat.delete();
         for (int i = 0; i < SS; i++) m_sel[i] = 0;
      end else begin
         for (int i = SS - 1; i > 0; i--) m_sel[i] = m_sel[i-1];
         m_sel[0] = int'(sel);
         if (!(gate && act)) begin
            m_run = 0; m_cnt = 0; pat.delete();
         end else if (!m_run) begin
            m_run = 1; build_pat(); m_len = pat.pop_front(); m_cnt = 0;
         end else if (m_cnt == m_len - 1) begin
            m_cnt = 0;
            if (pat.size() == 0) build_pat();
            m_len = pat.pop_front();
         end else begin
            m_cnt++;
         end
      end
   end

   // ---------------- per-cycle compare and period monitor ----------------
   int  cyc = 0;
   int  last_tick = 0;
   bit  have_last = 0;
   int  obs[$];
   bit  cmp_on = 0;

   always @(negedge clk) begin
      if (cmp_on) begin
         chk({cur_req, " R7"}, "tick", int'(tick), (m_run && m_cnt == 0) ? 1 : 0);
         chk({cur_req, " R7"}, "div_clk", int'(dclk), (m_run && m_cnt < m_len / 2) ? 1 : 0);
         chk("R9", "src_sel", int'(selo), m_sel[SS-1]);
      end
      cyc++;
      if (tick) begin
         if (have_last) obs.push_back(cyc - last_tick);
         last_tick = cyc;
         have_last = 1;
      end
   end

   task automatic cycles(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic run_phase(input int n, input int a, input int b, input int len);
      gate = 0; act = 0;
      cycles(3);
      nval = NW'(n); aval = AW'(a); bval = AW'(b);
      obs.delete(); have_last = 0;
      gate = 1; act = 1;
      cycles(len);
      gate = 0;
      cycles(2);
   endtask

   task automatic expect_seq(input string req, input int e[$]);
      for (int i = 0; i < e.size(); i++) begin
         if (i < obs.size()) chk(req, $sformatf("period[%0d]", i), obs[i], e[i]);
         else chk(req, $sformatf("period[%0d] missing", i), -1, e[i]);
      end
   endtask

   task automatic expect_sum(input int cnt, input int n, input int span, input int longs);
      int s = 0;
      int l = 0;
      for (int i = 0; i < cnt && i < obs.size(); i++) begin
         s += obs[i];
         if (obs[i] == n + 1) l++;
      end
      chk("R1", "pattern span", s, span);
      chk("R2", "long periods", l, longs);
   endtask

   initial begin
      int e[$];
      int seen;
      rst_n = 0;
      cycles(4);
      cur_req = "R10";
      chk("R10", "tick in reset", int'(tick), 0);
      chk("R10", "div_clk in reset", int'(dclk), 0);
      chk("R10", "src_sel in reset", int'(selo), 0);
      rst_n = 1;
      cmp_on = 1;
      cycles(2);

      cur_req = "R3"; sel = 2'd1;
      run_phase(4, 7, 2, 7 * 5 + 12);
      e = '{4, 4, 5, 4, 4, 5, 4};
      expect_seq("R3", e);
      expect_sum(7, 4, 30, 2);

      run_phase(3, 8, 4, 8 * 4 + 10);
      e = '{3, 4, 3, 4, 3, 4, 3, 4};
      expect_seq("R3", e);
      expect_sum(8, 3, 28, 4);

      cur_req = "R4"; sel = 2'd2;
      run_phase(3, 7, 5, 7 * 4 + 10);
      e = '{3, 4, 4, 3, 4, 4, 4};
      expect_seq("R4", e);
      expect_sum(7, 3, 26, 5);

      cur_req = "R5";
      run_phase(6, 5, 0, 40);
      e = '{6, 6, 6, 6, 6};
      expect_seq("R5", e);
      run_phase(1, 0, 0, 16);
      e = '{2, 2, 2, 2, 2};
      expect_seq("R5", e);
      run_phase(5, 3, 3, 30);
      e = '{5, 5, 5, 5};
      expect_seq("R5", e);

      // R6: ratio changed in the middle of the first pattern
      cur_req = "R6"; sel = 2'd3;
      gate = 0; act = 0;
      cycles(3);
      nval = 6'd4; aval = 4'd5; bval = 4'd2;
      obs.delete(); have_last = 0;
      gate = 1; act = 1;
      cycles(7);
      nval = 6'd9; aval = 4'd3; bval = 4'd1;
      cycles(60);
      gate = 0;
      cycles(2);
      e = '{4, 5, 4, 5, 4, 9, 9, 10};
      expect_seq("R6", e);

      // R8: each enable alone is not enough
      cur_req = "R8";
      nval = 6'd4; aval = 4'd0; bval = 4'd0;
      gate = 1; act = 1;
      cycles(10);
      gate = 0;
      seen = 0;
      repeat (12) begin @(negedge clk); seen += int'(tick) + int'(dclk); end
      chk("R8", "activity with gate off", seen, 0);
      gate = 1; act = 0;
      seen = 0;
      repeat (12) begin @(negedge clk); seen += int'(tick) + int'(dclk); end
      chk("R8", "activity with active off", seen, 0);
      act = 1;
      cycles(1);
      chk("R8", "first tick after enable", int'(tick), 1);
      cycles(5);
      gate = 0; act = 0;

      // R9: select pipe latency and codes
      cur_req = "R9";
      sel = 2'd2;
      cycles(4);
      sel = 2'd3;
      cycles(1);
      chk("R9", "select after one edge", int'(selo), 2);
      cycles(1);
      chk("R9", "select after two edges", int'(selo), 3);
      sel = 2'd0;
      cycles(3);
      chk("R9", "select returns to crystal", int'(selo), 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule